// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block sits between the clock synthesizer and the output drivers of a clock generator. It receives four running clocks: a host clock, a 66 MHz clock, a bus clock and a free-running bus clock. It gates them into four output groups under two active-low halt requests and an active-low sleep input. All three control inputs are asynchronous. Each request is brought into the clock domain it controls through a short synchronizer chain. A falling-edge register then applies the request, so a gated output can switch on or off only while its source clock is low.

The host halt request stops both the host group and the 66 MHz group. The bus halt request stops only the gated bus group. The free-running bus output ignores both halt requests and follows its input unless sleep is active. Sleep parks every output low, and while it is active the halt requests are don't-care. A stopped output always rests at logic 0. A restarted output always begins with a full-width high phase. The host, 66 MHz and bus clocks are assumed to have a fixed rational relationship, so every domain's latency can be stated as a count of its own rising edges.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_n is low, every output bit is 0.
- R2: A stopped output is held at logic 0 for the entire time its request stays active, and never rests at 1.
- R3: A request level sampled at a rising edge of a group's source clock first governs the high phase that starts SYNC_STAGES rising edges later. Earlier high phases follow earlier samples.
- R4: Every high pulse on any output lasts exactly half a period of its source clock, including the first pulse after a restart and the last pulse before a stop.
- R5: host_halt_n_i low stops both host_clk_o and mid_clk_o. It has no effect on bus_clk_o or bus_free_clk_o.
- R6: bus_halt_n_i low stops bus_clk_o only. host_clk_o, mid_clk_o and bus_free_clk_o keep toggling.
- R7: While sleep_n_i is high, bus_free_clk_o follows bus_free_clk_i regardless of either halt request.
- R8: While sleep_n_i is low, all four outputs are stopped low and both halt requests have no effect. Outputs restart under R3 timing once sleep_n_i returns high.
- R9: All bits of a group output vector carry identical values at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk_i | input | 1 | Running host clock |
| mid_clk_i | input | 1 | Running 66 MHz clock |
| bus_clk_i | input | 1 | Running bus clock |
| bus_free_clk_i | input | 1 | Free-running bus clock |
| sleep_n_i | input | 1 | Asynchronous active-low sleep; stops all outputs |
| host_halt_n_i | input | 1 | Asynchronous active-low stop for host and 66 MHz groups |
| bus_halt_n_i | input | 1 | Asynchronous active-low stop for the gated bus group |
| host_clk_o | output | CPU_W | Gated host clock group |
| mid_clk_o | output | M66_W | Gated 66 MHz clock group |
| bus_clk_o | output | PCI_W | Gated bus clock group |
| bus_free_clk_o | output | 1 | Free-running bus clock, stopped only by sleep |

## Verification
The assertions watch each domain on every falling edge of its clock. Once a request has been held steady for more than SYNC_STAGES rising edges, they require the output to be low (request active) or high (request inactive). This covers parking, restart, the mapping of requests to groups, and sleep overriding the halt requests. Other behaviour needs the bench's scenarios. These include exact latency when requests change often, short request pulses that must not produce runt pulses, the width of every high pulse, fan-out equality within a group, and the reset state. The bench compares each of these against its queue-based model at every base clock.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int CPU_W       = 6,
  parameter int M66_W       = 2,
  parameter int PCI_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             host_clk_i,
  input  logic             mid_clk_i,
  input  logic             bus_clk_i,
  input  logic             bus_free_clk_i,
  input  logic             sleep_n_i,
  input  logic             host_halt_n_i,
  input  logic             bus_halt_n_i,
  output logic [CPU_W-1:0] host_clk_o,
  output logic [M66_W-1:0] mid_clk_o,
  output logic [PCI_W-1:0] bus_clk_o,
  output logic             bus_free_clk_o
);
  localparam int NDOM = 4;

  logic [NDOM-1:0] dom_clk;
  logic [NDOM-1:0] dom_req;
  logic [NDOM-1:0] dom_gclk;

  assign dom_clk = {bus_free_clk_i, bus_clk_i, mid_clk_i, host_clk_i};
  assign dom_req = {sleep_n_i,
                    sleep_n_i & bus_halt_n_i,
                    sleep_n_i & host_halt_n_i,
                    sleep_n_i & host_halt_n_i};

  for (genvar g = 0; g < NDOM; g++) begin : dom_g
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_q;

    always_ff @(posedge dom_clk[g] or negedge rst_n)
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], dom_req[g]};

    always_ff @(negedge dom_clk[g] or negedge rst_n)
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= sync_q[SYNC_STAGES-1];

    assign dom_gclk[g] = dom_clk[g] & en_q;
  end

  assign host_clk_o     = {CPU_W{dom_gclk[0]}};
  assign mid_clk_o      = {M66_W{dom_gclk[1]}};
  assign bus_clk_o      = {PCI_W{dom_gclk[2]}};
  assign bus_free_clk_o = dom_gclk[3];
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic rst_n,
  input logic host_clk_i,
  input logic mid_clk_i,
  input logic bus_clk_i,
  input logic bus_free_clk_i,
  input logic sleep_n_i,
  input logic host_halt_n_i,
  input logic bus_halt_n_i,
  input logic host_o,
  input logic mid_o,
  input logic bus_o,
  input logic free_o
);
  localparam int unsigned SAT = 1000;

  logic [3:0] clk_v, req_v, halted, running;

  assign clk_v = {bus_free_clk_i, bus_clk_i, mid_clk_i, host_clk_i};
  assign req_v = {sleep_n_i, sleep_n_i & bus_halt_n_i,
                  sleep_n_i & host_halt_n_i, sleep_n_i & host_halt_n_i};

  for (genvar d = 0; d < 4; d++) begin : cnt_g
    int unsigned halt_cnt, run_cnt;
    always_ff @(posedge clk_v[d] or negedge rst_n)
      if (!rst_n) begin
        halt_cnt <= 0;
        run_cnt  <= 0;
      end else begin
        halt_cnt <= req_v[d] ? 0 : ((halt_cnt < SAT) ? halt_cnt + 1 : halt_cnt);
        run_cnt  <= req_v[d] ? ((run_cnt < SAT) ? run_cnt + 1 : run_cnt) : 0;
      end
    assign halted[d]  = halt_cnt > SYNC_STAGES;
    assign running[d] = run_cnt > SYNC_STAGES;
  end

  // R2
  host_parked_chk: assert property (@(negedge host_clk_i) disable iff (!rst_n)
    halted[0] |-> !host_o);
  // R3
  host_resume_chk: assert property (@(negedge host_clk_i) disable iff (!rst_n)
    running[0] |-> host_o);
  // R5
  mid_parked_chk: assert property (@(negedge mid_clk_i) disable iff (!rst_n)
    halted[1] |-> !mid_o);
  // R5
  mid_resume_chk: assert property (@(negedge mid_clk_i) disable iff (!rst_n)
    running[1] |-> mid_o);
  // R6
  bus_parked_chk: assert property (@(negedge bus_clk_i) disable iff (!rst_n)
    halted[2] |-> !bus_o);
  // R6
  bus_resume_chk: assert property (@(negedge bus_clk_i) disable iff (!rst_n)
    running[2] |-> bus_o);
  // R7
  free_resume_chk: assert property (@(negedge bus_free_clk_i) disable iff (!rst_n)
    running[3] |-> free_o);
  // R8
  free_parked_chk: assert property (@(negedge bus_free_clk_i) disable iff (!rst_n)
    halted[3] |-> !free_o);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .rst_n          (rst_n),
  .host_clk_i     (host_clk_i),
  .mid_clk_i      (mid_clk_i),
  .bus_clk_i      (bus_clk_i),
  .bus_free_clk_i (bus_free_clk_i),
  .sleep_n_i      (sleep_n_i),
  .host_halt_n_i  (host_halt_n_i),
  .bus_halt_n_i   (bus_halt_n_i),
  .host_o         (host_clk_o[0]),
  .mid_o          (mid_clk_o[0]),
  .bus_o          (bus_clk_o[0]),
  .free_o         (bus_free_clk_o)
);

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;
  localparam int CPU_W = 6, M66_W = 2, PCI_W = 5, SYNC = 2;

  logic clk_base = 1'b0;
  always #2 clk_base = ~clk_base;

  logic [2:0] div = '0;
  always @(posedge clk_base) div <= div + 3'd1;

  logic rst_n = 1'b1;
  logic sleep_n = 1'b1, host_halt_n = 1'b1, bus_halt_n = 1'b1;
  logic [CPU_W-1:0] host_o;
  logic [M66_W-1:0] mid_o;
  logic [PCI_W-1:0] bus_o;
  logic free_o;

  clk_stop_gate #(.CPU_W(CPU_W), .M66_W(M66_W), .PCI_W(PCI_W), .SYNC_STAGES(SYNC)) dut_i (
    .rst_n(rst_n), .host_clk_i(div[0]), .mid_clk_i(div[1]), .bus_clk_i(div[2]),
    .bus_free_clk_i(div[2]), .sleep_n_i(sleep_n), .host_halt_n_i(host_halt_n),
    .bus_halt_n_i(bus_halt_n), .host_clk_o(host_o), .mid_clk_o(mid_o),
    .bus_clk_o(bus_o), .bus_free_clk_o(free_o));

  int checks = 0, failures = 0;
  bit started = 0;

  logic [3:0] m_clk, m_req, m_en;
  assign m_clk = {div[2], div[2], div[1], div[0]};
  assign m_req = {sleep_n, sleep_n & bus_halt_n, sleep_n & host_halt_n, sleep_n & host_halt_n};

  for (genvar d = 0; d < 4; d++) begin : ref_g
    bit q[$];
    bit en = 1'b0;
    always @(posedge m_clk[d] or negedge rst_n)
      if (!rst_n) q.delete();
      else begin
        q.push_front(m_req[d]);
        if (q.size() > SYNC) void'(q.pop_back());
      end
    always @(negedge m_clk[d] or negedge rst_n)
      if (!rst_n) en = 1'b0;
      else en = (q.size() == SYNC) ? q[SYNC-1] : 1'b0;
    assign m_en[d] = en;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string pick_tag(input int d, input bit e);
    if (!rst_n) return "R1";
    if (!sleep_n) return "R8";
    if (m_en[d] != m_req[d]) return "R3";
    if (!e && m_clk[d]) return "R2";
    case (d)
      0, 1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  int half_len[4] = '{1, 2, 4, 4};
  int hi_len[4] = '{0, 0, 0, 0};

  always @(negedge clk_base) if (started) begin
    logic [3:0] act;
    act = {free_o, bus_o[0], mid_o[0], host_o[0]};
    for (int d = 0; d < 4; d++) begin
      bit e;
      e = m_clk[d] & m_en[d];
      check(act[d] == e, pick_tag(d, e), act[d], e);
      if (act[d]) hi_len[d]++;
      else if (hi_len[d] > 0) begin
        check(hi_len[d] == half_len[d], "R4", hi_len[d], half_len[d]);
        hi_len[d] = 0;
      end
    end
    // R9
    check(host_o == {CPU_W{host_o[0]}}, "R9", int'(host_o), int'({CPU_W{host_o[0]}}));
    check(mid_o == {M66_W{mid_o[0]}}, "R9", int'(mid_o), int'({M66_W{mid_o[0]}}));
    check(bus_o == {PCI_W{bus_o[0]}}, "R9", int'(bus_o), int'({PCI_W{bus_o[0]}}));
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_base);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    started = 1;
    wait_n(6);
    // R1: outputs all zero during reset (checked by the compare loop)
    check({free_o, bus_o, mid_o, host_o} == '0, "R1", int'({free_o, bus_o, mid_o, host_o}), 0);
    rst_n = 1'b1;
    wait_n(40);
    host_halt_n = 1'b0; wait_n(60);           // R5 host and mid stop, bus runs
    host_halt_n = 1'b1; wait_n(60);
    bus_halt_n = 1'b0;  wait_n(60);           // R6 bus stop only
    bus_halt_n = 1'b1;  wait_n(60);
    host_halt_n = 1'b0; bus_halt_n = 1'b0; wait_n(40);
    host_halt_n = 1'b1; wait_n(40);
    bus_halt_n = 1'b1;  wait_n(40);
    for (int i = 0; i < 6; i++) begin         // R3 R4 short requests
      host_halt_n = 1'b0; wait_n(i % 3 + 1);
      host_halt_n = 1'b1; wait_n(7);
      bus_halt_n = 1'b0;  wait_n(i % 4 + 1);
      bus_halt_n = 1'b1;  wait_n(9);
    end
    sleep_n = 1'b0;                           // R8 halts are don't-care
    for (int i = 0; i < 12; i++) begin
      host_halt_n = i[0]; bus_halt_n = i[1]; wait_n(5);
    end
    host_halt_n = 1'b1; bus_halt_n = 1'b1;
    sleep_n = 1'b1; wait_n(60);               // R7 free output back
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_base);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule